// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This block watches a set of external input lines and folds them into a single interrupt request. Each line has its own trigger rule. The rule can fire on a rising edge, a falling edge, either edge, a high level or a low level. Every input passes through a synchronizer on the system clock before any detection is done. A detected event sets a sticky pending bit for that line. A per-line enable mask decides which pending bits may drive the shared interrupt output.

Software reaches the block through a small word-addressed register bus with fixed offsets. There is a bank of trigger-rule registers, one mask register and one pending register. A handler reads the pending register, writes the same value back to acknowledge everything it saw, and then services those lines. To quiesce the block, software clears the mask and then clears the pending bits.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: After reset, every trigger-rule field, every mask bit and every pending bit reads 0, and `irq` is low.
- R2: The trigger rule of line n is the 4-bit field at bits [4*(n%8)+3 : 4*(n%8)] of the register at byte offset 0x200 + 4*(n/8). It reads back as written.
- R3: Rule code 0x0 sets pending bit n once the synchronized line goes from 0 to 1. A 1-to-0 change does not set it.
- R4: Rule code 0x1 sets pending bit n once the synchronized line goes from 1 to 0. A 0-to-1 change does not set it.
- R5: Rule code 0x4 sets pending bit n on either transition of the synchronized line.
- R6: Rule code 0x2 sets pending bit n on every cycle the synchronized line is 1. A clear has no lasting effect until the line returns to 0.
- R7: Rule code 0x3 sets pending bit n on every cycle the synchronized line is 0. A clear has no lasting effect until the line returns to 1.
- R8: Rule codes 0x5 through 0xF never set a pending bit, whatever the line does.
- R9: The pending register is at offset 0x214, with bit n for line n. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Writing back a value just read clears every bit set in that value.
- R10: If an event on line n and a write that clears bit n land in the same cycle, bit n stays set.
- R11: The mask register is at offset 0x210, with bit n for line n. A line sets its pending bit whether or not it is masked. `irq` is the OR over n of (pending n AND mask n), registered one cycle.
- R12: Writing 0 to the mask register and then writing all ones to the pending register leaves `irq` low and the pending register at 0, as long as the edge-triggered lines stay still.
- R13: A read of any offset other than the rule bank, the mask and the pending register returns 0. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| eint_pins | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; data is valid the next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, held between reads |
| irq | output | 1 | Combined, registered interrupt request |

## Verification
The bench uses the defaults: 32 lines, 12-bit offsets, 32-bit data and a two-stage synchronizer. This fills all four rule registers, so the top line (31) and the last field of the last rule register are both exercised. A line set to a level rule reaches the pending register in the same cycle as a clear, so the bench can hit the priority between event and acknowledge. A 32-line width also means writing all ones to the pending register covers the full width.

// File: rtl/eint_pkg.sv
package eint_pkg;

  // Trigger rule codes held in each 4-bit rule field
  typedef enum logic [3:0] {
    TRIG_RISE = 4'h0,
    TRIG_FALL = 4'h1,
    TRIG_HIGH = 4'h2,
    TRIG_LOW  = 4'h3,
    TRIG_BOTH = 4'h4
  } trig_e;

  localparam int RULE_W      = 4;
  localparam int RULE_BASE   = 'h200;
  localparam int MASK_OFS    = 'h210;
  localparam int PEND_OFS    = 'h214;
  localparam int WORD_BYTES  = 4;

endpackage

// File: rtl/eint_rst_sync.sv
module eint_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) rst_q <= 2'b00;
    else              rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n = rst_q[1];

endmodule

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      line_sync,
  input  logic [RULE_W*N-1:0] rule_flat,
  output logic [N-1:0]      hit
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  assign prev_d = line_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar n = 0; n < N; n++) begin : g_line
    logic [RULE_W-1:0] rule;
    logic              rise;
    logic              fall;
    assign rule = rule_flat[RULE_W*n +: RULE_W];
    assign rise = line_sync[n] & ~prev_q[n];
    assign fall = ~line_sync[n] & prev_q[n];
    always_comb begin
      case (rule)
        TRIG_RISE: hit[n] = rise;
        TRIG_FALL: hit[n] = fall;
        TRIG_HIGH: hit[n] = line_sync[n];
        TRIG_LOW:  hit[n] = ~line_sync[n];
        TRIG_BOTH: hit[n] = rise | fall;
        default:   hit[n] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N-1:0]        hit,
  output logic [DATA_W-1:0]   rdata,
  output logic [RULE_W*N-1:0] rule_flat,
  output logic [N-1:0]        mask,
  output logic [N-1:0]        pending
);

  localparam int FIELDS = DATA_W / RULE_W;
  localparam int NREG   = (N + FIELDS - 1) / FIELDS;

  logic [RULE_W*N-1:0]   rule_q, rule_d;
  logic [N-1:0]          mask_q, mask_d;
  logic [N-1:0]          pend_q, pend_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic [NREG*DATA_W-1:0] rule_pad;
  logic                  mask_sel, pend_sel;
  logic [N-1:0]          clr;

  assign mask_sel = (addr == ADDR_W'(MASK_OFS));
  assign pend_sel = (addr == ADDR_W'(PEND_OFS));

  // Rule fields: one write decode per line
  for (genvar n = 0; n < N; n++) begin : g_rule
    localparam int REG = n / FIELDS;
    localparam int SH  = RULE_W * (n % FIELDS);
    logic sel;
    assign sel = wr_en && (addr == ADDR_W'(RULE_BASE + WORD_BYTES * REG));
    assign rule_d[RULE_W*n +: RULE_W] = sel ? wdata[SH +: RULE_W]
                                            : rule_q[RULE_W*n +: RULE_W];
  end

  // Mask and pending next state; a new event outranks a clear
  always_comb begin
    mask_d = (wr_en && mask_sel) ? wdata[N-1:0] : mask_q;
    clr    = (wr_en && pend_sel) ? wdata[N-1:0] : '0;
    pend_d = (pend_q & ~clr) | hit;
  end

  // Read decode
  always_comb begin
    rule_pad = '0;
    rule_pad[RULE_W*N-1:0] = rule_q;
  end

  always_comb begin
    rdata_d = '0;
    if (mask_sel) rdata_d[N-1:0] = mask_q;
    if (pend_sel) rdata_d[N-1:0] = pend_q;
    for (int k = 0; k < NREG; k++) begin
      if (addr == ADDR_W'(RULE_BASE + WORD_BYTES * k))
        rdata_d = rule_pad[DATA_W*k +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rule_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      rule_q <= rule_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign rule_flat = rule_q;
  assign mask      = mask_q;
  assign pending   = pend_q;

endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] eint_pins,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);

  logic                          rst_n_sync;
  logic [NUM_LINES-1:0]          line_sync;
  logic [NUM_LINES-1:0]          hit_vec;
  logic [RULE_W*NUM_LINES-1:0]   rule_vec;
  logic [NUM_LINES-1:0]          mask_vec;
  logic [NUM_LINES-1:0]          pend_vec;
  logic                          irq_q, irq_d;

  eint_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n       (rst_n_sync)
  );

  eint_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .async_in (eint_pins),
    .sync_out (line_sync)
  );

  eint_detect #(.N(NUM_LINES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .line_sync (line_sync),
    .rule_flat (rule_vec),
    .hit       (hit_vec)
  );

  eint_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .hit       (hit_vec),
    .rdata     (bus_rdata),
    .rule_flat (rule_vec),
    .mask      (mask_vec),
    .pending   (pend_vec)
  );

  assign irq_d = |(pend_vec & mask_vec);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/eint_checker.sv
module eint_checker
  import eint_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        hit,
  input logic [N-1:0]        pending,
  input logic [N-1:0]        mask,
  input logic [RULE_W*N-1:0] rule_flat,
  input logic                irq,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata
);

  localparam int FIELDS = DATA_W / RULE_W;
  localparam int NREG   = (N + FIELDS - 1) / FIELDS;

  logic [N-1:0] bad_rule;
  logic         mapped;
  logic         pend_wr;

  always_comb begin
    for (int n = 0; n < N; n++)
      bad_rule[n] = (rule_flat[RULE_W*n +: RULE_W] > 4'h4);
  end

  always_comb begin
    mapped = (bus_addr == ADDR_W'(MASK_OFS)) || (bus_addr == ADDR_W'(PEND_OFS));
    for (int k = 0; k < NREG; k++)
      if (bus_addr == ADDR_W'(RULE_BASE + WORD_BYTES * k)) mapped = 1'b1;
  end

  assign pend_wr = bus_wr_en && (bus_addr == ADDR_W'(PEND_OFS));

  // R3: a pending bit only rises after a detected event
  assert_only_events_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(hit)) == '0));

  // R8: unused rule codes never detect
  assert_bad_rule_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & bad_rule) == '0);

  // R9: a written one clears its bit unless an event coincides
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pending & $past(bus_wdata[N-1:0]) & ~$past(hit)) == '0));

  // R10: an event always leaves its bit set, clear or not
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pending & $past(hit)) == $past(hit)));

  // R11: the request follows masked pending one cycle later
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(pending) & $past(mask)))));

  // R13: unmapped offsets read as zero
  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !mapped) |=> (bus_rdata == '0));

endmodule

bind gpio_eint_ctrl eint_checker #(
  .N      (NUM_LINES),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_eint_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .hit       (hit_vec),
  .pending   (pend_vec),
  .mask      (mask_vec),
  .rule_flat (rule_vec),
  .irq       (irq),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/gpio_eint_ctrl_bench.sv
module gpio_eint_ctrl_bench;

  localparam int NL = 32;
  localparam logic [11:0] A_RULE0 = 12'h200;
  localparam logic [11:0] A_MASK  = 12'h210;
  localparam logic [11:0] A_PEND  = 12'h214;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NL-1:0] pins;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_eint_ctrl u_gpio_eint_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .eint_pins (pins),
    .bus_wr_en (wr_en),
    .bus_rd_en (rd_en),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pins[n] = v;
    settle();
  endtask

  task automatic set_rule(input int n, input logic [3:0] code);
    logic [31:0] w;
    logic [11:0] a;
    a = A_RULE0 + 12'(4 * (n / 8));
    bus_read(a, w);
    w[4*(n%8) +: 4] = code;
    bus_write(a, w);
    settle();
  endtask

  task automatic clear_all();
    bus_write(A_PEND, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      bus_read(A_RULE0 + 12'(4 * k), v);
      check("R1 rule reg after reset", v, 32'h0);
    end
    bus_read(A_MASK, v);  check("R1 mask after reset", v, 32'h0);
    bus_read(A_PEND, v);  check("R1 pending after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) bus_write(A_RULE0 + 12'(4 * k), 32'h7777_7777 ^ (32'h0101_0101 << k));
    for (int k = 0; k < 4; k++) begin
      bus_read(A_RULE0 + 12'(4 * k), v);
      check("R2 rule readback", v, 32'h7777_7777 ^ (32'h0101_0101 << k));
    end
    for (int k = 0; k < 4; k++) bus_write(A_RULE0 + 12'(4 * k), 32'h7777_7777);
    // line 31 lives in the top field of the last rule register
    set_rule(31, 4'h0);
    bus_read(A_RULE0 + 12'hC, v);
    check("R2 line 31 field", v, 32'h0777_7777);
    set_rule(31, 4'h7);
    clear_all();
  endtask

  task automatic t_rise();
    logic [31:0] v;
    set_rule(3, 4'h0); clear_all();
    set_pin(3, 1'b1);
    bus_read(A_PEND, v); check("R3 rising sets", v, 32'h8);
    clear_all();
    set_pin(3, 1'b0);
    bus_read(A_PEND, v); check("R3 falling ignored", v, 32'h0);
    set_rule(3, 4'h7);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    set_rule(12, 4'h1); clear_all();
    set_pin(12, 1'b1);
    bus_read(A_PEND, v); check("R4 rising ignored", v, 32'h0);
    set_pin(12, 1'b0);
    bus_read(A_PEND, v); check("R4 falling sets", v, 32'h1000);
    clear_all(); set_rule(12, 4'h7);
  endtask

  task automatic t_both();
    logic [31:0] v;
    set_rule(20, 4'h4); clear_all();
    set_pin(20, 1'b1);
    bus_read(A_PEND, v); check("R5 rise sets", v, 32'h0010_0000);
    clear_all();
    set_pin(20, 1'b0);
    bus_read(A_PEND, v); check("R5 fall sets", v, 32'h0010_0000);
    clear_all(); set_rule(20, 4'h7);
  endtask

  task automatic t_high();
    logic [31:0] v;
    set_rule(31, 4'h2); clear_all();
    bus_read(A_PEND, v); check("R6 idle low no event", v, 32'h0);
    set_pin(31, 1'b1);
    clear_all();
    bus_read(A_PEND, v); check("R6 clear while high", v, 32'h8000_0000);
    set_pin(31, 1'b0);
    clear_all();
    bus_read(A_PEND, v); check("R6 clear after low", v, 32'h0);
    set_rule(31, 4'h7);
  endtask

  task automatic t_low();
    logic [31:0] v;
    set_pin(8, 1'b1);
    set_rule(8, 4'h3); clear_all();
    bus_read(A_PEND, v); check("R7 idle high no event", v, 32'h0);
    set_pin(8, 1'b0);
    clear_all();
    bus_read(A_PEND, v); check("R7 clear while low", v, 32'h100);
    set_pin(8, 1'b1);
    clear_all();
    bus_read(A_PEND, v); check("R7 clear after high", v, 32'h0);
    set_rule(8, 4'h7);
    set_pin(8, 1'b0);
  endtask

  task automatic t_bad_codes();
    logic [31:0] v;
    for (int c = 5; c < 16; c++) begin
      set_rule(5, 4'(c)); clear_all();
      set_pin(5, 1'b1);
      set_pin(5, 1'b0);
      bus_read(A_PEND, v); check("R8 unused code silent", v, 32'h0);
    end
    set_rule(5, 4'h7);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    set_rule(1, 4'h0); set_rule(2, 4'h0); clear_all();
    set_pin(1, 1'b1); set_pin(2, 1'b1);
    bus_write(A_PEND, 32'h0); settle();
    bus_read(A_PEND, v); check("R9 zero write keeps", v, 32'h6);
    bus_write(A_PEND, 32'h2); settle();
    bus_read(A_PEND, v); check("R9 partial clear", v, 32'h4);
    bus_write(A_PEND, v); settle();
    bus_read(A_PEND, v); check("R9 write back read value", v, 32'h0);
    set_pin(1, 1'b0); set_pin(2, 1'b0);
    set_rule(1, 4'h7); set_rule(2, 4'h7);
  endtask

  task automatic t_race();
    logic [31:0] v;
    set_rule(14, 4'h0); clear_all();
    @(negedge clk); pins[14] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = A_PEND; wdata = 32'h4000;
    @(negedge clk); wr_en = 1'b0;
    settle();
    bus_read(A_PEND, v); check("R10 event beats clear", v, 32'h4000);
    clear_all();
    bus_read(A_PEND, v); check("R10 later clear works", v, 32'h0);
    set_pin(14, 1'b0); set_rule(14, 4'h7);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    set_rule(7, 4'h0); clear_all();
    set_pin(7, 1'b1);
    bus_read(A_PEND, v); check("R11 masked line still pends", v, 32'h80);
    check("R11 irq low when masked", {31'h0, irq}, 32'h0);
    bus_write(A_MASK, 32'h40); settle();
    check("R11 irq low other mask bit", {31'h0, irq}, 32'h0);
    bus_write(A_MASK, 32'h80); settle();
    check("R11 irq high when unmasked", {31'h0, irq}, 32'h1);
    bus_read(A_MASK, v); check("R11 mask readback", v, 32'h80);
    set_pin(7, 1'b0);
  endtask

  task automatic t_quiesce();
    logic [31:0] v;
    set_rule(9, 4'h0); set_pin(9, 1'b1);
    bus_write(A_MASK, 32'hFFFF_FFFF); settle();
    check("R12 irq before quiesce", {31'h0, irq}, 32'h1);
    bus_write(A_MASK, 32'h0);
    bus_write(A_PEND, 32'hFFFF_FFFF); settle();
    check("R12 irq after quiesce", {31'h0, irq}, 32'h0);
    bus_read(A_PEND, v); check("R12 pending after quiesce", v, 32'h0);
    set_pin(9, 1'b0); set_rule(9, 4'h7); set_rule(7, 4'h7);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(A_MASK, 32'h5);
    bus_write(12'h218, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_read(12'h218, v); check("R13 read 0x218", v, 32'h0);
    bus_read(12'h100, v); check("R13 read 0x100", v, 32'h0);
    bus_read(12'h20C + 12'h10, v); check("R13 read 0x21C", v, 32'h0);
    bus_read(A_MASK, v); check("R13 mask untouched", v, 32'h5);
    bus_read(A_RULE0, v); check("R13 rules untouched", v, 32'h7777_7777);
    bus_write(A_MASK, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_high();
    t_low();
    t_bad_codes();
    t_w1c();
    t_race();
    t_mask();
    t_quiesce();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule